// File: doc/BRIEF.md
# Reconfigurable Fine-Grain Logic Cell

This block is one cell of a fine-grained programmable array. It picks three single-bit operands, each from any of eight neighbour or routing wires, and from them forms one result bit. The function is chosen at run time: a two-input lookup table covering every Boolean function of two variables, a 2:1 selector with optional inversion on either data leg or on the select, a fixed 0 or 1, or a straight or inverted copy of one operand. The result either goes straight out or passes through a D flip-flop with a clock enable and an asynchronous clear. The cell output can be steered onto any subset of four direction outputs.

The cell holds three configuration bytes loaded through a plain byte-write port. Address 0 holds the function byte. Address 1 holds the selectors for the two table or data operands. Address 2 holds the select-operand selector and the direction enables. A new setting takes effect on the clock edge that writes it, so one cell can be reprogrammed while its neighbours keep running.

Top module: `logic_cell`

## Requirements
- R1: Operands A and B take `src_in[idx]`, with idx from route byte 1 bits [2:0] for A and bits [5:3] for B. Operand S takes idx from route byte 2 bits [2:0]. Any of the eight sources can feed any operand.
- R2: A write with `cfg_we` high stores `cfg_data` on the rising clock edge: address 0 to the function byte, 1 to route byte 1, 2 to route byte 2. The function byte holds the class in bits [7:6] (00 table, 01 selector, 10 constant, 11 pass), the register enable in bit 5, an ignored bit 4, and the parameter bits P in [3:0].
- R3: In the table class the result is P[{B,A}], so every two-input function is reachable.
- R4: In the selector class the result is (S^P[2]) ? (B^P[1]) : (A^P[0]).
- R5: In the constant class the result is P[0], whatever the sources and bit 4 hold.
- R6: In the pass class the result is A^P[0] (buffer when 0, inverter when 1).
- R7: With function bit 5 clear, `cell_q` follows the sources combinationally, with no clock edge needed.
- R8: With function bit 5 set, `cell_q` is a flop that loads the result only on a rising edge with `cell_ce` high, and holds its value otherwise.
- R9: A high `clr` forces the flop, and so a registered `cell_q`, to 0 at once, without waiting for a clock edge.
- R10: `dir_out[i]` equals `cell_q` when route byte 2 bit 4+i is set, and is 0 otherwise.
- R11: A low `rst_n` clears all configuration bytes and the flop, giving `cell_q`=0 and `dir_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset of configuration and flop |
| clr | input | 1 | Global asynchronous clear of the cell flop |
| cell_ce | input | 1 | Synchronous clock enable of the cell flop |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Configuration byte address (0 function, 1 and 2 routing) |
| cfg_data | input | 8 | Configuration byte value |
| src_in | input | 8 | The eight candidate source wires |
| cell_q | output | 1 | Cell result |
| dir_out | output | 4 | Directional copies of the result, gated by enables |

## Verification
The hardest situation to reach is the registered path under its control signals: a flop that has to hold across edges while a new function is written, and a clear that lands between edges. From the ports alone, hold and capture look the same unless the function changes meaning between them. The stimulus therefore rewrites the function byte from constant 1 to constant 0 while the enable is low, and checks that the output keeps the old value across several edges. It raises the clear half a cycle before an edge and samples the output before that edge arrives. A registered pass function then changes its source mid-cycle to show that the output waits for the edge.

// File: rtl/lc_pkg.sv
package lc_pkg;

   localparam int CFG_W = 8;

   typedef enum logic [1:0] {
      CLS_TABLE = 2'b00,
      CLS_MUX   = 2'b01,
      CLS_CONST = 2'b10,
      CLS_PASS  = 2'b11
   } lc_class_e;

   typedef struct packed {
      lc_class_e  cls;
      logic       regd;
      logic       spare;
      logic [3:0] prm;
   } lc_fn_t;

   // configuration byte addresses
   localparam logic [1:0] ADR_FN  = 2'd0;
   localparam logic [1:0] ADR_RTA = 2'd1;
   localparam logic [1:0] ADR_RTB = 2'd2;

   // selector polarity bits inside prm for the mux class
   localparam int MUX_INV_D0  = 0;
   localparam int MUX_INV_D1  = 1;
   localparam int MUX_INV_SEL = 2;

endpackage

// File: rtl/lc_cfg_store.sv
module lc_cfg_store
   import lc_pkg::*;
#(
   parameter int N_CFG = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [1:0]                  addr,
   input  logic [CFG_W-1:0]            wdata,
   output logic [N_CFG-1:0][CFG_W-1:0] cfg_q
);

   localparam int ADR_W = 2;

   if (N_CFG > (1 << ADR_W)) begin : g_bad_depth
      $error("lc_cfg_store: N_CFG exceeds address space");
   end

   for (genvar g = 0; g < N_CFG; g++) begin : g_byte
      logic hit;
      assign hit = we && (addr == ADR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cfg_q[g] <= '0;
         else if (hit) cfg_q[g] <= wdata;
      end
   end

endmodule

// File: rtl/lc_src_pick.sv
module lc_src_pick #(
   parameter int N_SRC = 8,
   localparam int SEL_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             y
);

   if (N_SRC < 2 || (1 << SEL_W) != N_SRC) begin : g_bad_src
      $error("lc_src_pick: N_SRC must be a power of two, at least 2");
   end

   always_comb begin
      y = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) y = src[i];
      end
   end

endmodule

// File: rtl/lc_func_core.sv
module lc_func_core
   import lc_pkg::*;
(
   input  lc_class_e  cls,
   input  logic [3:0] prm,
   input  logic       op_a,
   input  logic       op_b,
   input  logic       op_s,
   output logic       y
);

   logic       d0, d1, s_eff;
   logic [1:0] tbl_idx;

   assign d0      = op_a ^ prm[MUX_INV_D0];
   assign d1      = op_b ^ prm[MUX_INV_D1];
   assign s_eff   = op_s ^ prm[MUX_INV_SEL];
   assign tbl_idx = {op_b, op_a};

   always_comb begin
      unique case (cls)
         CLS_TABLE: y = prm[tbl_idx];
         CLS_MUX:   y = s_eff ? d1 : d0;
         CLS_CONST: y = prm[0];
         CLS_PASS:  y = op_a ^ prm[0];
         default:   y = 1'b0;
      endcase
   end

endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage #(
   parameter bit HAS_REG = 1'b1,
   parameter int N_DIR   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ce,
   input  logic             reg_en,
   input  logic             d,
   input  logic [N_DIR-1:0] dir_en,
   output logic             ff_q,
   output logic             q,
   output logic [N_DIR-1:0] dir_out
);

   if (N_DIR < 1) begin : g_bad_dir
      $error("lc_out_stage: N_DIR must be at least 1");
   end

   if (HAS_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n or posedge clr) begin
         if (!rst_n)            ff_q <= 1'b0;
         else if (clr)          ff_q <= 1'b0;
         else if (reg_en && ce) ff_q <= d;
      end
      assign q = reg_en ? ff_q : d;
   end else begin : g_noreg
      assign ff_q = 1'b0;
      assign q    = d;
   end

   for (genvar g = 0; g < N_DIR; g++) begin : g_dir
      assign dir_out[g] = dir_en[g] & q;
   end

endmodule

// File: rtl/logic_cell.sv
module logic_cell
   import lc_pkg::*;
#(
   parameter int N_SRC   = 8,
   parameter int N_DIR   = 4,
   parameter bit HAS_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cell_ce,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [7:0]       cfg_data,
   input  logic [N_SRC-1:0] src_in,
   output logic             cell_q,
   output logic [N_DIR-1:0] dir_out
);

   localparam int SEL_W  = $clog2(N_SRC);
   localparam int N_CFG  = 3;
   localparam int N_OPS  = 3;
   localparam int DIR_LO = 4;

   if (2 * SEL_W > CFG_W) begin : g_bad_rta
      $error("logic_cell: two selectors do not fit one byte");
   end
   if (SEL_W > DIR_LO || DIR_LO + N_DIR > CFG_W) begin : g_bad_rtb
      $error("logic_cell: selector and direction enables do not fit one byte");
   end

   logic [N_CFG-1:0][CFG_W-1:0] cfg_q;
   lc_fn_t                      fn_s;
   logic [CFG_W-1:0]            fn_byte, rt_a, rt_b;
   logic [N_OPS-1:0][SEL_W-1:0] op_sel;
   logic [N_OPS-1:0]            op_val;
   logic [N_DIR-1:0]            dir_en;
   logic                        comb_y, ff_q, reg_mode;

   lc_cfg_store #(.N_CFG(N_CFG)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_data),
      .cfg_q (cfg_q)
   );

   assign fn_byte = cfg_q[ADR_FN];
   assign rt_a    = cfg_q[ADR_RTA];
   assign rt_b    = cfg_q[ADR_RTB];
   assign fn_s    = lc_fn_t'(fn_byte);

   assign op_sel[0] = rt_a[SEL_W-1:0];
   assign op_sel[1] = rt_a[2*SEL_W-1:SEL_W];
   assign op_sel[2] = rt_b[SEL_W-1:0];
   assign dir_en    = rt_b[DIR_LO+N_DIR-1:DIR_LO];

   for (genvar g = 0; g < N_OPS; g++) begin : g_op
      lc_src_pick #(.N_SRC(N_SRC)) u_pick (
         .src (src_in),
         .sel (op_sel[g]),
         .y   (op_val[g])
      );
   end

   lc_func_core u_core (
      .cls  (fn_s.cls),
      .prm  (fn_s.prm),
      .op_a (op_val[0]),
      .op_b (op_val[1]),
      .op_s (op_val[2]),
      .y    (comb_y)
   );

   assign reg_mode = HAS_REG && fn_s.regd;

   lc_out_stage #(.HAS_REG(HAS_REG), .N_DIR(N_DIR)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .ce      (cell_ce),
      .reg_en  (reg_mode),
      .d       (comb_y),
      .dir_en  (dir_en),
      .ff_q    (ff_q),
      .q       (cell_q),
      .dir_out (dir_out)
   );

endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk #(
   parameter int N_DIR = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             cell_ce,
   input logic             cfg_we,
   input logic [1:0]       cfg_addr,
   input logic [7:0]       cfg_data,
   input logic [7:0]       fn_byte,
   input logic [7:0]       rt_b,
   input logic [N_DIR-1:0] dir_en,
   input logic             reg_mode,
   input logic             comb_y,
   input logic             ff_q,
   input logic             cell_q,
   input logic [N_DIR-1:0] dir_out
);

   // R2
   fn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_addr == 2'd0 |=> fn_byte == $past(cfg_data));

   // R2
   rtb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_addr == 2'd2 |=> rt_b == $past(cfg_data));

   // R5
   const_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_mode && fn_byte[7:6] == 2'b10 |-> cell_q == fn_byte[0]);

   // R8
   ff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      reg_mode && !cell_ce |=> $stable(ff_q));

   // R8
   ff_load_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      reg_mode && cell_ce |=> ff_q == $past(comb_y));

   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && reg_mode |-> cell_q == 1'b0);

   // R10
   dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_out & ~dir_en) == '0);

endmodule

bind logic_cell logic_cell_chk #(.N_DIR(N_DIR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .cell_ce  (cell_ce),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_data (cfg_data),
   .fn_byte  (fn_byte),
   .rt_b     (rt_b),
   .dir_en   (dir_en),
   .reg_mode (reg_mode),
   .comb_y   (comb_y),
   .ff_q     (ff_q),
   .cell_q   (cell_q),
   .dir_out  (dir_out)
);

// File: tb/logic_cell_tb.sv
module logic_cell_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       cell_ce = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_data = '0;
   logic [7:0] src_in = '0;
   logic       cell_q;
   logic [3:0] dir_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   logic_cell u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .cell_ce  (cell_ce),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_data (cfg_data),
      .src_in   (src_in),
      .cell_q   (cell_q),
      .dir_out  (dir_out)
   );

   // {function byte, route byte 1, source pattern, expected result, tag}
   localparam int NV = 17;
   localparam logic [28:0] VEC [NV] = '{
      {8'h08, 8'h08, 8'h03, 1'b1, 4'd3},  // AND, a=b=1
      {8'h08, 8'h08, 8'h01, 1'b0, 4'd3},  // AND, a=1 b=0
      {8'h06, 8'h15, 8'h20, 1'b1, 4'd1},  // XOR a=src5 b=src2
      {8'h06, 8'h15, 8'h24, 1'b0, 4'd1},
      {8'h07, 8'h15, 8'h00, 1'b1, 4'd3},  // NAND
      {8'h06, 8'h33, 8'h08, 1'b1, 4'd1},  // XOR a=src3 b=src6
      {8'h06, 8'h33, 8'h48, 1'b0, 4'd1},
      {8'h40, 8'h08, 8'h82, 1'b1, 4'd4},  // mux s=1 -> b
      {8'h40, 8'h08, 8'h02, 1'b0, 4'd4},  // mux s=0 -> a
      {8'h44, 8'h08, 8'h02, 1'b1, 4'd4},  // inverted select
      {8'h41, 8'h08, 8'h00, 1'b1, 4'd4},  // inverted a leg
      {8'h42, 8'h08, 8'h82, 1'b0, 4'd4},  // inverted b leg
      {8'h81, 8'h08, 8'h00, 1'b1, 4'd5},  // const 1
      {8'h80, 8'h08, 8'hFF, 1'b0, 4'd5},  // const 0
      {8'h91, 8'h08, 8'h00, 1'b1, 4'd5},  // const 1, spare bit set
      {8'hC0, 8'h08, 8'h01, 1'b1, 4'd6},  // buffer
      {8'hC1, 8'h08, 8'h01, 1'b0, 4'd6}   // inverter
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_addr = a;
      cfg_data = d;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   initial begin
      // R11: reset state
      #5;
      chk("R11 reset q", {7'd0, cell_q}, 8'h00);
      chk("R11 reset dir", {4'd0, dir_out}, 8'h00);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      src_in = 8'hFF;
      #2;
      chk("R11 after reset q", {7'd0, cell_q}, 8'h00);

      // R1 R3 R4 R5 R6 R7: vector walk, direction enables all on
      wr(2'd2, 8'hF7);
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, VEC[i][28:21]);
         wr(2'd1, VEC[i][20:13]);
         src_in = VEC[i][12:5];
         #2;
         chk($sformatf("R%0d R1 R7 vec%0d q", VEC[i][3:0], i),
             {7'd0, cell_q}, {7'd0, VEC[i][4]});
         chk($sformatf("R10 vec%0d dir", i), {4'd0, dir_out}, {4'd0, {4{VEC[i][4]}}});
      end

      // R10: direction enables
      wr(2'd0, 8'h81);
      wr(2'd2, 8'h50);
      #2 chk("R10 dir 0101", {4'd0, dir_out}, 8'h05);
      wr(2'd2, 8'hA0);
      #2 chk("R10 dir 1010", {4'd0, dir_out}, 8'h0A);
      wr(2'd2, 8'h00);
      #2 chk("R10 dir off", {4'd0, dir_out}, 8'h00);
      wr(2'd2, 8'hF0);

      // R8: registered path, enable low holds
      cell_ce = 1'b0;
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      wr(2'd0, 8'hA1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 hold with ce low", {7'd0, cell_q}, 8'h00);
      cell_ce = 1'b1;
      #2 chk("R8 no change before edge", {7'd0, cell_q}, 8'h00);
      @(posedge clk) #1;
      chk("R8 load on edge", {7'd0, cell_q}, 8'h01);
      @(negedge clk) cell_ce = 1'b0;
      wr(2'd0, 8'hA0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 hold across rewrite", {7'd0, cell_q}, 8'h01);
      cell_ce = 1'b1;
      @(posedge clk) #1;
      chk("R8 load const0", {7'd0, cell_q}, 8'h00);

      // R9: asynchronous clear
      wr(2'd0, 8'hA1);
      @(posedge clk) #1;
      chk("R8 load const1", {7'd0, cell_q}, 8'h01);
      @(negedge clk) clr = 1'b1;
      #2 chk("R9 clear before edge", {7'd0, cell_q}, 8'h00);
      @(negedge clk) clr = 1'b0;
      #2 chk("R9 held through edge", {7'd0, cell_q}, 8'h00);
      @(posedge clk) #1;
      chk("R9 reload after clear", {7'd0, cell_q}, 8'h01);

      // R8 R7: registered pass vs bypass
      src_in = 8'h00;
      wr(2'd1, 8'h08);
      wr(2'd0, 8'hE0);
      @(posedge clk);
      @(negedge clk) src_in = 8'h01;
      #2 chk("R8 pass waits for edge", {7'd0, cell_q}, 8'h00);
      @(posedge clk) #1;
      chk("R8 pass after edge", {7'd0, cell_q}, 8'h01);
      wr(2'd0, 8'hC0);
      @(negedge clk) src_in = 8'h00;
      #2 chk("R7 bypass immediate", {7'd0, cell_q}, 8'h00);

      // R11: reset mid-run clears configuration
      wr(2'd0, 8'h81);
      @(negedge clk) rst_n = 1'b0;
      #2 chk("R11 reset q", {7'd0, cell_q}, 8'h00);
      chk("R11 reset dir", {4'd0, dir_out}, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      src_in = 8'hFF;
      #2 chk("R11 config cleared", {3'd0, cell_q, dir_out}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule